// File: doc/BRIEF.md
# LED chaser pattern sequencer

This block drives an eight-lamp bar through a fixed cycle of ten light patterns. From all-off the bar fills in from the left, one lamp per step, until three lamps are lit. That three-lamp window then slides right until it covers bits 4..2. The next step jumps to the rightmost three lamps, and the bar then empties one lamp per step. After the single rightmost lamp it returns to all-off. A free-running prescaler produces a one-cycle advance strobe every `DIV` clocks, and the pattern moves one step on each strobe.

The sequence state is kept in a five-bit twisted-ring (Johnson) register, and the lamp outputs are decoded from it. There is no direction control and no other input besides clock and reset.

Top module: `led_chase`

## Requirements
- R1: While `rst_ni` is low, `led_o` is 8'h00 without waiting for a clock edge, and the prescaler is cleared.
- R2: After reset is released, the pattern advances on the DIV-th rising edge and then on every DIV-th edge after that. The advance strobe is high for exactly one cycle in every DIV.
- R3: Between two advance strobes, `led_o` does not change.
- R4: Counting from the step after all-off, the steps are: 8'h80, 8'hC0, 8'hE0, 8'h70, 8'h38, 8'h1C, 8'h07, 8'h03, 8'h01. Bit 7 is the leftmost lamp.
- R5: The step after 8'h01 is 8'h00, so the cycle of ten repeats without end.
- R6: A reset asserted in the same cycle as an advance strobe wins. The outputs go to 8'h00, and the next pattern after release is 8'h80, reached DIV edges after release.
- R7: The state is a five-bit Johnson code, so `led_o` only ever shows one of the ten listed patterns. Any unused code is replaced with the all-off code at the next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| led_o | output | 8 | Lamp outputs; bit 7 is the leftmost lamp |

## Verification
A reset and an advance strobe can fall in the same cycle. The bench provokes this by asserting reset on the falling edge just before a strobe edge, when the prescaler is at its last count. The result is judged correct if the bar shows all-off immediately, stays all-off across that edge, and restarts the full sweep from step zero after release. The same reset is also applied at a point with no strobe, and the bench checks that both give the same restart timing.

// File: rtl/led_chase_pkg.sv
package led_chase_pkg;
  localparam int unsigned JC_W  = 5;
  localparam int unsigned LED_W = 8;
  localparam int unsigned N_STEPS = 2 * JC_W;

  typedef logic [JC_W-1:0]  jc_t;
  typedef logic [LED_W-1:0] led_t;

  localparam jc_t JC_IDLE = '0;

  // Twisted-ring advance: shift left, feed back inverted MSB
  function automatic jc_t jc_next(input jc_t s);
    return {s[JC_W-2:0], ~s[JC_W-1]};
  endfunction

  // Legal codes have at most one 0/1 boundary along the word
  function automatic logic jc_legal(input jc_t s);
    return $countones(s[JC_W-1:1] ^ s[JC_W-2:0]) <= 1;
  endfunction
endpackage

// File: rtl/led_chase_prescaler.sv
module led_chase_prescaler #(
  parameter int unsigned DIV = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign step_o = 1'b1;
    end else begin : g_cnt
      localparam int unsigned CNT_W = $clog2(DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end

      assign step_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/led_chase_ring.sv
module led_chase_ring
  import led_chase_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output jc_t  state_o
);
  jc_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      state_q <= JC_IDLE;
    else if (step_i)
      state_q <= jc_legal(state_q) ? jc_next(state_q) : JC_IDLE;
  end

  assign state_o = state_q;
endmodule

// File: rtl/led_chase_decode.sv
module led_chase_decode
  import led_chase_pkg::*;
(
  input  jc_t  state_i,
  output led_t led_o
);
  always_comb begin
    unique case (state_i)
      5'b00001: led_o = 8'b1000_0000;
      5'b00011: led_o = 8'b1100_0000;
      5'b00111: led_o = 8'b1110_0000;
      5'b01111: led_o = 8'b0111_0000;
      5'b11111: led_o = 8'b0011_1000;
      5'b11110: led_o = 8'b0001_1100;
      5'b11100: led_o = 8'b0000_0111;
      5'b11000: led_o = 8'b0000_0011;
      5'b10000: led_o = 8'b0000_0001;
      default:  led_o = 8'b0000_0000;
    endcase
  end
endmodule

// File: rtl/led_chase.sv
module led_chase #(
  parameter int unsigned DIV = 1_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [7:0] led_o
);
  import led_chase_pkg::*;

  logic step_en;
  jc_t  state_q;

  led_chase_prescaler #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_o (step_en)
  );

  led_chase_ring u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_en),
    .state_o (state_q)
  );

  led_chase_decode u_dec (
    .state_i (state_q),
    .led_o   (led_o)
  );
endmodule

// File: rtl/led_chase_chk.sv
module led_chase_chk #(
  parameter int unsigned DIV = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       step_en,
  input logic [4:0] state_q,
  input logic [7:0] led_o
);
  int unsigned gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gap_q <= 0;
    else if (step_en) gap_q <= 0;
    else              gap_q <= gap_q + 1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_dark_R1: assert (led_o == 8'h00);
  end

  assert_strobe_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en |-> gap_q == DIV - 1);

  assert_strobe_late_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < DIV);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en |=> $stable(led_o));

  assert_step_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en |=> led_o != $past(led_o));

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en && led_o == 8'h01) |=> led_o == 8'h00);

  assert_legal_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q[4:1] ^ state_q[3:0]) <= 1);
endmodule

bind led_chase led_chase_chk #(.DIV(DIV)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .step_en (step_en),
  .state_q (state_q),
  .led_o   (led_o)
);

// File: tb/led_chase_test.sv
`timescale 1ns/1ps
module led_chase_test;
  localparam int unsigned DIV = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] led_o;

  int n_cmp = 0;
  int n_bad = 0;
  int k;

  led_chase #(.DIV(DIV)) uut (.clk_i(clk_i), .rst_ni(rst_ni), .led_o(led_o));

  always #2 clk_i = ~clk_i;

  function automatic logic [7:0] pat(input int s);
    if (s == 0)      return 8'h00;
    else if (s <= 3) return 8'(8'hFF << (8 - s));
    else if (s <= 6) return 8'(8'hE0 >> (s - 3));
    else             return 8'(8'hFF >> (s - 2));
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    n_cmp++;
    if (led_o !== exp) begin
      n_bad++;
      $display("FAIL %s k=%0d led_o=%h expected=%h", req, k, led_o, exp);
    end
  endtask

  task automatic check_legal();
    logic ok = 1'b0;
    for (int s = 0; s < 10; s++) if (led_o === pat(s)) ok = 1'b1;
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R7 k=%0d led_o=%h expected=one of ten patterns", k, led_o);
    end
  endtask

  // Run n edges from the current count, comparing after each edge
  task automatic sweep(input int n);
    logic [7:0] prev;
    for (int i = 0; i < n; i++) begin
      prev = led_o;
      @(posedge clk_i); @(negedge clk_i);
      k++;
      if (k % DIV != 0) check("R3", prev);
      else if ((k / DIV) % 10 == 0 && k > 0) check("R5", 8'h00);
      else if (k == DIV) check("R2", 8'h80);
      else check("R4", pat((k / DIV) % 10));
      check_legal();
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #0.5;
    check("R1", 8'h00);
    @(posedge clk_i); @(negedge clk_i);
    check("R1", 8'h00);
    rst_ni = 1'b1;
    k = 0;
  endtask

  initial begin
    rst_ni = 1'b0;
    k = 0;
    #1;
    check("R1", 8'h00);
    @(negedge clk_i); @(negedge clk_i);
    check("R1", 8'h00);
    rst_ni = 1'b1;
    k = 0;
    sweep(DIV * 10 * 2 + DIV * 3);

    // Reset where the next edge would carry a strobe (R6)
    while (k % DIV != DIV - 1) sweep(1);
    do_reset();
    check("R6", 8'h00);
    sweep(DIV * 10 + DIV * 5);

    // Reset at a non-strobe point
    while (k % DIV != 1) sweep(1);
    do_reset();
    sweep(DIV * 10 * 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog k=%0d led_o=%h expected=run completion", k, led_o);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule